// File: doc/BRIEF.md
# Trace Capture Controller

This block decides, cycle by cycle, whether an incoming trace packet is stored in an on-chip trace RAM, and where. It keeps a write pointer into the RAM and a capture-enable flag. The flag can be set by software. It can also be set or cleared by external start and stop trigger lines, each of which has its own enable. A watermark comparator watches the pointer. When the pointer reaches the watermark, it can stop capture, raise a debug halt request, or do both.

A stop caused by the watermark is latched. While that latch is set, a start trigger cannot resume capture. Software clears the latch by rewriting either the pointer or the watermark. The RAM write port is registered, so a plain synchronous RAM sits directly behind it. Software reaches the block through a simple single-cycle write port with three targets: control, pointer and flow. The control word is visible on a read-back output.

Top module: `trc_capture_ctl`

## Requirements
- R1: While the enable flag (control bit 31) is 1 and `trc_valid` is high, the next cycle shows `ram_we`=1 with `ram_addr` equal to the current pointer and `ram_wdata` equal to the packet. The pointer then advances by one.
- R2: When start-trigger enable (control bit 5) is 1 and `trig_start` is high, the enable flag reads 1 in the next cycle. When bit 5 is 0, `trig_start` has no effect.
- R3: When stop-trigger enable (control bit 6) is 1 and `trig_stop` is high, the enable flag reads 0 in the next cycle.
- R4: If both enabled triggers are high in the same cycle, the stop wins and the enable flag reads 0.
- R5: With auto-stop (flow bit 0) set, a capture whose advanced pointer equals the watermark (flow bits ADDR_W+1..2) clears the enable flag in the same edge that registers the write.
- R6: After a watermark stop, start triggers leave the flag at 0 until software writes the pointer (`wr_sel`=1) or the flow word (`wr_sel`=2). After that write, a start trigger works again.
- R7: `halt_req` is a register that holds the halt-request bit (control bit 9) AND `dbg_en`, both sampled at the previous edge.
- R8: With auto-halt (flow bit 1) set, a capture whose advanced pointer equals the watermark sets control bit 9.
- R9: With mask field 0, or with a mask field of ADDR_W or more, the pointer wraps from all-ones to 0.
- R10: With mask field M, where 0<M<ADDR_W, only the low M pointer bits count and wrap. The upper bits hold.
- R11: A control write (`wr_sel`=0) loads bits 31, 9, 6, 5 and 4..0. All other bits of `ctrl_word` read 0.
- R12: After reset, `ctrl_word` is 0, `ram_we` is 0, `halt_req` is 0 and the watermark latch is clear.
- R13: While the enable flag is 0, packets are ignored: `ram_we` stays 0 and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trc_valid | input | 1 | Trace packet strobe |
| trc_data | input | DATA_W | Trace packet |
| trig_start | input | 1 | External start trigger |
| trig_stop | input | 1 | External stop trigger |
| dbg_en | input | 1 | Invasive-debug enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 pointer, 2 flow |
| wr_data | input | 32 | Register write data |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | DATA_W | RAM write data |
| halt_req | output | 1 | Debug halt request |
| ctrl_word | output | 32 | Control word read-back |

## Verification
The properties assume that a software write and a trigger or packet do not land in the same cycle in a way that makes the write override the trigger. Each antecedent therefore excludes the matching write. The bench keeps `wr_en` low whenever it pulses a trigger or sends a packet, and it changes inputs only on falling edges. Watermark and pointer values are chosen so that every match and wrap is reached within a handful of packets.

// File: rtl/trc_capture_pkg.sv
package trc_capture_pkg;
  localparam int CW_EN       = 31;
  localparam int CW_HALT     = 9;
  localparam int CW_STOP_EN  = 6;
  localparam int CW_START_EN = 5;
  localparam int MASK_W      = 5;

  localparam int FW_AUTOSTOP = 0;
  localparam int FW_AUTOHALT = 1;
  localparam int FW_WM_LSB   = 2;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PTR  = 2'd1,
    SEL_FLOW = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/trc_ptr_unit.sv
module trc_ptr_unit
  import trc_capture_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              adv,
  input  logic [MASK_W-1:0] mask,
  output logic [ADDR_W-1:0] ptr_q,
  output logic [ADDR_W-1:0] ptr_adv
);
  logic              full_wrap;
  logic [ADDR_W-1:0] low_mask;
  logic [ADDR_W-1:0] inc;

  assign full_wrap = (mask == '0) || (32'(mask) >= ADDR_W);

  for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_mask
    assign low_mask[gi] = full_wrap || (32'(mask) > gi);
  end

  assign inc     = ptr_q + 1'b1;
  assign ptr_adv = (ptr_q & ~low_mask) | (inc & low_mask);

  always_ff @(posedge clk) begin
    if (rst)       ptr_q <= '0;
    else if (load) ptr_q <= load_val;
    else if (adv)  ptr_q <= ptr_adv;
  end
endmodule

// File: rtl/trc_wm_unit.sv
module trc_wm_unit
  import trc_capture_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flow_wr,
  input  logic              ptr_wr,
  input  logic [31:0]       wr_data,
  input  logic              write_done,
  input  logic [ADDR_W-1:0] ptr_adv,
  output logic              stop_hit,
  output logic              halt_hit,
  output logic              wm_lock
);
  logic [ADDR_W-1:0] wm_q;
  logic              autostop_q;
  logic              autohalt_q;
  logic              match;

  assign match    = write_done && !flow_wr && (ptr_adv == wm_q);
  assign stop_hit = match && autostop_q;
  assign halt_hit = match && autohalt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wm_q       <= '0;
      autostop_q <= 1'b0;
      autohalt_q <= 1'b0;
    end else if (flow_wr) begin
      wm_q       <= wr_data[FW_WM_LSB +: ADDR_W];
      autostop_q <= wr_data[FW_AUTOSTOP];
      autohalt_q <= wr_data[FW_AUTOHALT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     wm_lock <= 1'b0;
    else if (flow_wr || ptr_wr)  wm_lock <= 1'b0;
    else if (stop_hit)           wm_lock <= 1'b1;
  end
endmodule

// File: rtl/trc_ctrl_unit.sv
module trc_ctrl_unit
  import trc_capture_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [31:0]       wr_data,
  input  logic              trig_start,
  input  logic              trig_stop,
  input  logic              stop_hit,
  input  logic              halt_hit,
  input  logic              wm_lock,
  input  logic              dbg_en,
  output logic              en_q,
  output logic              halt_q,
  output logic              start_en_q,
  output logic              stop_en_q,
  output logic [MASK_W-1:0] mask_q,
  output logic              halt_req
);
  logic en_nxt;
  logic halt_nxt;

  always_comb begin
    en_nxt = en_q;
    if (ctrl_wr)                                   en_nxt = wr_data[CW_EN];
    else if (stop_en_q && trig_stop)               en_nxt = 1'b0;
    else if (stop_hit)                             en_nxt = 1'b0;
    else if (start_en_q && trig_start && !wm_lock) en_nxt = 1'b1;
  end

  always_comb begin
    halt_nxt = halt_q;
    if (ctrl_wr)       halt_nxt = wr_data[CW_HALT];
    else if (halt_hit) halt_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      halt_q     <= 1'b0;
      start_en_q <= 1'b0;
      stop_en_q  <= 1'b0;
      mask_q     <= '0;
      halt_req   <= 1'b0;
    end else begin
      en_q     <= en_nxt;
      halt_q   <= halt_nxt;
      halt_req <= halt_nxt && dbg_en;
      if (ctrl_wr) begin
        start_en_q <= wr_data[CW_START_EN];
        stop_en_q  <= wr_data[CW_STOP_EN];
        mask_q     <= wr_data[MASK_W-1:0];
      end
    end
  end
endmodule

// File: rtl/trc_capture_ctl.sv
module trc_capture_ctl
  import trc_capture_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trc_valid,
  input  logic [DATA_W-1:0] trc_data,
  input  logic              trig_start,
  input  logic              trig_stop,
  input  logic              dbg_en,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [31:0]       wr_data,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              halt_req,
  output logic [31:0]       ctrl_word
);
  logic              ctrl_wr;
  logic              ptr_wr;
  logic              flow_wr;
  logic              do_write;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] ptr_adv;
  logic              stop_hit;
  logic              halt_hit;
  logic              wm_lock;
  logic              en_q;
  logic              halt_q;
  logic              start_en_q;
  logic              stop_en_q;
  logic [MASK_W-1:0] mask_q;

  assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
  assign ptr_wr   = wr_en && (wr_sel == SEL_PTR);
  assign flow_wr  = wr_en && (wr_sel == SEL_FLOW);
  assign do_write = en_q && trc_valid && !ptr_wr;

  trc_ptr_unit #(.ADDR_W(ADDR_W)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .load     (ptr_wr),
    .load_val (wr_data[ADDR_W-1:0]),
    .adv      (do_write),
    .mask     (mask_q),
    .ptr_q    (ptr_q),
    .ptr_adv  (ptr_adv)
  );

  trc_wm_unit #(.ADDR_W(ADDR_W)) u_wm (
    .clk        (clk),
    .rst        (rst),
    .flow_wr    (flow_wr),
    .ptr_wr     (ptr_wr),
    .wr_data    (wr_data),
    .write_done (do_write),
    .ptr_adv    (ptr_adv),
    .stop_hit   (stop_hit),
    .halt_hit   (halt_hit),
    .wm_lock    (wm_lock)
  );

  trc_ctrl_unit u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ctrl_wr    (ctrl_wr),
    .wr_data    (wr_data),
    .trig_start (trig_start),
    .trig_stop  (trig_stop),
    .stop_hit   (stop_hit),
    .halt_hit   (halt_hit),
    .wm_lock    (wm_lock),
    .dbg_en     (dbg_en),
    .en_q       (en_q),
    .halt_q     (halt_q),
    .start_en_q (start_en_q),
    .stop_en_q  (stop_en_q),
    .mask_q     (mask_q),
    .halt_req   (halt_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we <= do_write;
      if (do_write) begin
        ram_addr  <= ptr_q;
        ram_wdata <= trc_data;
      end
    end
  end

  always_comb begin
    ctrl_word                  = '0;
    ctrl_word[CW_EN]           = en_q;
    ctrl_word[CW_HALT]         = halt_q;
    ctrl_word[CW_STOP_EN]      = stop_en_q;
    ctrl_word[CW_START_EN]     = start_en_q;
    ctrl_word[MASK_W-1:0]      = mask_q;
  end
endmodule

// File: rtl/trc_capture_chk.sv
module trc_capture_chk (
  input logic        clk,
  input logic        rst,
  input logic        trc_valid,
  input logic        trig_stop,
  input logic        dbg_en,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [31:0] ctrl_word,
  input logic        ram_we,
  input logic        halt_req,
  input logic        wm_lock
);
  AST_CAPTURE_WRITES: assert property (@(posedge clk) disable iff (rst)
    (ctrl_word[31] && trc_valid && !(wr_en && wr_sel == 2'd1)) |=> ram_we); // R1

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !ctrl_word[31] |=> !ram_we); // R13

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ctrl_word[6] && trig_stop && !(wr_en && wr_sel == 2'd0)) |=> !ctrl_word[31]); // R3

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wm_lock && !ctrl_word[31] && !wr_en) |=> !ctrl_word[31]); // R6

  AST_HALT_NEEDS_BIT: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> ctrl_word[9]); // R7

  AST_HALT_NEEDS_DBG: assert property (@(posedge clk) disable iff (rst)
    !dbg_en |=> !halt_req); // R7
endmodule

bind trc_capture_ctl trc_capture_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .trc_valid (trc_valid),
  .trig_stop (trig_stop),
  .dbg_en    (dbg_en),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .ctrl_word (ctrl_word),
  .ram_we    (ram_we),
  .halt_req  (halt_req),
  .wm_lock   (wm_lock)
);

// File: tb/trc_capture_ctl_bench.sv
module trc_capture_ctl_bench;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              trc_valid = 1'b0;
  logic [DATA_W-1:0] trc_data = '0;
  logic              trig_start = 1'b0;
  logic              trig_stop = 1'b0;
  logic              dbg_en = 1'b0;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_sel = 2'd3;
  logic [31:0]       wr_data = '0;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata;
  logic              halt_req;
  logic [31:0]       ctrl_word;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [ADDR_W+DATA_W-1:0] exp_q[$];
  string                    tag_q[$];

  always #10 clk = ~clk;

  trc_capture_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_trc_capture_ctl (
    .clk        (clk),
    .rst        (rst),
    .trc_valid  (trc_valid),
    .trc_data   (trc_data),
    .trig_start (trig_start),
    .trig_stop  (trig_stop),
    .dbg_en     (dbg_en),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .halt_req   (halt_req),
    .ctrl_word  (ctrl_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever the design writes the RAM
  always @(negedge clk) begin
    if (!rst && ram_we) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R13 actual write addr %h expected no write", ram_addr);
      end else begin
        logic [ADDR_W+DATA_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({ram_addr, ram_wdata} !== e) begin
          errors++;
          $display("FAIL %s actual %h expected %h", t, {ram_addr, ram_wdata}, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  // driver: sends one packet and pushes the expected write
  task automatic send_pkt(input logic [DATA_W-1:0] d, input logic expect_wr,
                          input logic [ADDR_W-1:0] addr, input string req);
    @(negedge clk);
    trc_valid = 1'b1; trc_data = d;
    if (expect_wr) begin
      exp_q.push_back({addr, d});
      tag_q.push_back(req);
    end
    @(negedge clk);
    trc_valid = 1'b0;
    check(req, 32'(ram_we), 32'(expect_wr));
  endtask

  task automatic pulse(input logic s, input logic p);
    @(negedge clk);
    trig_start = s; trig_stop = p;
    @(negedge clk);
    trig_start = 1'b0; trig_stop = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 ctrl", ctrl_word, 32'h0);
    check("R12 we", 32'(ram_we), 32'h0);
    check("R12 halt", 32'(halt_req), 32'h0);

    // R13: disabled, packet ignored
    send_pkt(32'hDEAD0000, 1'b0, '0, "R13");

    // R11: control layout
    wr_reg(2'd0, 32'hFFFF_FFFF);
    check("R11 layout", ctrl_word, 32'h8000_027F);
    wr_reg(2'd0, 32'h8000_0000);
    check("R11 en only", ctrl_word, 32'h8000_0000);

    // R1: capture from pointer 0 (pointer untouched by the ignored packet, R13)
    send_pkt(32'h1111_0001, 1'b1, 8'd0, "R1");
    send_pkt(32'h1111_0002, 1'b1, 8'd1, "R1");
    send_pkt(32'h1111_0003, 1'b1, 8'd2, "R1");

    // R9: full wrap
    wr_reg(2'd1, 32'd255);
    send_pkt(32'h2222_0001, 1'b1, 8'd255, "R9");
    send_pkt(32'h2222_0002, 1'b1, 8'd0, "R9");

    // R10: mask 2 keeps upper bits
    wr_reg(2'd0, 32'h8000_0002);
    wr_reg(2'd1, 32'h15);
    send_pkt(32'h3333_0001, 1'b1, 8'h15, "R10");
    send_pkt(32'h3333_0002, 1'b1, 8'h16, "R10");
    send_pkt(32'h3333_0003, 1'b1, 8'h17, "R10");
    send_pkt(32'h3333_0004, 1'b1, 8'h14, "R10");

    // R2: start without enable has no effect, then with enable
    wr_reg(2'd0, 32'h0);
    pulse(1'b1, 1'b0);
    check("R2 no enable", 32'(ctrl_word[31]), 32'h0);
    wr_reg(2'd0, 32'h0000_0060);
    pulse(1'b1, 1'b0);
    check("R2 start", 32'(ctrl_word[31]), 32'h1);

    // R3: stop trigger
    pulse(1'b0, 1'b1);
    check("R3 stop", 32'(ctrl_word[31]), 32'h0);

    // R4: both triggers while running -> stop wins
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b1);
    check("R4 both", 32'(ctrl_word[31]), 32'h0);

    // R5 and R6: watermark auto-stop and latch
    wr_reg(2'd0, 32'h8000_0020);
    wr_reg(2'd1, 32'd10);
    wr_reg(2'd2, (32'd12 << 2) | 32'd1);
    send_pkt(32'h4444_0001, 1'b1, 8'd10, "R5");
    check("R5 still on", 32'(ctrl_word[31]), 32'h1);
    send_pkt(32'h4444_0002, 1'b1, 8'd11, "R5");
    check("R5 auto stop", 32'(ctrl_word[31]), 32'h0);
    send_pkt(32'h4444_0003, 1'b0, '0, "R13");
    pulse(1'b1, 1'b0);
    check("R6 start blocked", 32'(ctrl_word[31]), 32'h0);
    wr_reg(2'd1, 32'd20);
    pulse(1'b1, 1'b0);
    check("R6 start after rewrite", 32'(ctrl_word[31]), 32'h1);
    send_pkt(32'h4444_0004, 1'b1, 8'd20, "R6");

    // R8 and R7: auto-halt gated by dbg_en
    wr_reg(2'd2, (32'd22 << 2) | 32'd2);
    send_pkt(32'h5555_0001, 1'b1, 8'd21, "R8");
    check("R8 halt bit", 32'(ctrl_word[9]), 32'h1);
    check("R7 gated", 32'(halt_req), 32'h0);
    @(negedge clk);
    dbg_en = 1'b1;
    @(negedge clk);
    check("R7 asserted", 32'(halt_req), 32'h1);
    check("R8 capture continues", 32'(ctrl_word[31]), 32'h1);
    wr_reg(2'd0, 32'h0);
    check("R7 cleared", 32'(halt_req), 32'h0);

    repeat (2) @(negedge clk);
    check("R1 scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule